// File: doc/BRIEF.md
# Indexed Audio Codec Control Register Front End

This block is the byte-wide host-side register front end of an audio codec. The host sees four byte ports, chosen by a 2-bit select: an index port, an indirect data port, a status port and a programmed-I/O data port. Up to 32 indirect control registers sit behind the index/data pair. The index port picks a register and the data port reads or writes it. How many index bits count depends on an extended-mode bit held in one of the indirect registers.

Writes to the playback sample-format register pass only while a mode-change enable is open. A partial enable protects the low nibble of that register. Raising the mode-change enable starts an auto-calibration countdown when the interface configuration asks for calibration. The error/initialisation register then reports "calibration busy" until the host has polled it enough times.

The block owns the codec interrupt. A playback engine raises it through a one-cycle event input. The host acknowledges it through the status port or through the indirect alternate-status register. The playback engine receives three things from this block: the format register, the playback-enable bit and the interrupt-enable bit.

Calibration is handled by a two-state machine. `CAL_IDLE` moves to `CAL_BUSY` on a qualified rising edge of the mode-change enable. `CAL_BUSY` reloads its counter on a new qualified edge. It moves back to `CAL_IDLE` on the poll that drains the counter. The interrupt is handled by a second two-state machine. `IRQ_IDLE` moves to `IRQ_PENDING` on a playback event. `IRQ_PENDING` moves back to `IRQ_IDLE` on a status-port write or a PI acknowledge, unless an event arrives in the same cycle.

Top module: `codec_host_regs`

## Requirements
- R1: After reset the index port reads 0x40 and the status and PIO ports read 0x00. Indirect registers 2, 3, 4, 5, 18 and 19 read 0x88. Registers 6 and 7 read 0x80. Register 9 reads 0x08. Register 12 reads 0x8A. Registers 25 and 26 read 0xA0. Every other indirect register reads 0x00.
- R2: Bit 7 of the index port is never stored, and an index port read always returns bit 7 as 0. Bit 6 of the index port is the mode-change enable (MCE).
- R3: When bit 6 (MODE2) of register 12 is clear, only index bits 3:0 select the indirect register. When MODE2 is set, index bits 4:0 select it.
- R4: A data write to register 12 changes only its bit 6, which takes the written bit 6. All other bits of register 12 keep their value.
- R5: Bit 5 of register 9 always reads 0, and all other written bits of register 9 are stored. Output `play_en` follows register 9 bit 0. Output `irq_en` follows register 10 bit 1.
- R6: Data writes to register 11 have no effect on its stored value.
- R7: A write to register 8 stores the full byte while MCE is set. With MCE clear and register 24 bit 4 set (partial enable), only bits 7:4 change. With both clear the write is dropped. `fmt_q` always equals register 8.
- R8: An index write that takes MCE from 0 to 1 loads the calibration counter with `CAL_READS`, but only when register 9 bits 4:3 are not both 0. A rising MCE edge reloads a counter that is already running.
- R9: While the calibration counter is nonzero, a read of register 11 returns bit 5 set, and that read decrements the counter by one. Once the counter reaches zero, bit 5 reads as 0.
- R10: A one-cycle `play_evt` pulse sets status bit 0 (INT) and register 24 bit 4 (PI), and asserts `irq`. All three are visible from the next cycle.
- R11: Any write to the status port clears INT, `irq` and register 24 bits 6:4. If `play_evt` arrives in the same cycle, INT, PI and `irq` end up set.
- R12: A data write to register 24 with bit 4 clear, while PI is set, clears INT and `irq`. A write with bit 4 set leaves the interrupt pending.
- R13: The PIO data port always reads 0x00, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 2 | Port select: 0 index, 1 indirect data, 2 status, 3 PIO data |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_rd | input | 1 | Read strobe; carries read side effects |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for the selected port, combinational |
| play_evt | input | 1 | Playback-interrupt event from the playback engine |
| fmt_q | output | 8 | Current playback format register |
| play_en | output | 1 | Playback enable |
| irq_en | output | 1 | Interrupt enable |
| irq | output | 1 | Interrupt line, level |

## Verification
The hardest states to reach are the ones behind the index register. The calibration counter only starts on a rising MCE edge while register 9 bits 4:3 are set, and every later poll of register 11 changes that counter. Because of this, the whole run is driven against a bench-side model that tracks MCE, the index width and the remaining poll count from the requirements. Register-9 sweeps and index sweeps that start calibration by accident are then still predicted exactly. A same-cycle playback event and status write is forced by driving both strobes on one edge.

// File: rtl/codec_regs_pkg.sv
package codec_regs_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [1:0] {
        PORT_INDEX  = 2'd0,
        PORT_DATA   = 2'd1,
        PORT_STATUS = 2'd2,
        PORT_PIO    = 2'd3
    } port_e;

    typedef enum logic {
        CAL_IDLE = 1'b0,
        CAL_BUSY = 1'b1
    } cal_state_e;

    typedef enum logic {
        IRQ_IDLE    = 1'b0,
        IRQ_PENDING = 1'b1
    } irq_state_e;

    // register numbers the behaviour depends on
    localparam int REG_FMT     = 8;
    localparam int REG_IFCFG   = 9;
    localparam int REG_PINCTL  = 10;
    localparam int REG_ERRSTAT = 11;
    localparam int REG_MODEID  = 12;
    localparam int REG_ALTSTAT = 24;

    // bit positions
    localparam int MCE_BIT     = 6;
    localparam int MODE2_BIT   = 6;
    localparam int PEN_BIT     = 0;
    localparam int IEN_BIT     = 1;
    localparam int IFCFG_RSVD  = 5;
    localparam int PI_BIT      = 4;
    localparam int PMCE_BIT    = 4;
    localparam int CALBSY_BIT  = 5;
    localparam int INT_BIT     = 0;

    localparam logic [BYTE_W-1:0] ALT_FLAG_MASK = 8'h70;

    function automatic logic [BYTE_W-1:0] reg_reset(int idx);
        unique case (idx)
            2, 3, 4, 5, 18, 19: return 8'h88;
            6, 7:               return 8'h80;
            REG_IFCFG:          return 8'h08;
            REG_MODEID:         return 8'h8A;
            25, 26:             return 8'hA0;
            default:            return 8'h00;
        endcase
    endfunction

    // value a data-port write leaves in an ordinary register
    function automatic logic [BYTE_W-1:0] merge_write(
        int idx, logic [BYTE_W-1:0] old_v, logic [BYTE_W-1:0] wd,
        logic mce, logic pmce);
        logic [BYTE_W-1:0] v;
        v = wd;
        unique case (idx)
            REG_ERRSTAT: v = old_v;
            REG_MODEID: begin
                v = old_v;
                v[MODE2_BIT] = wd[MODE2_BIT];
            end
            REG_IFCFG: v[IFCFG_RSVD] = 1'b0;
            REG_FMT: begin
                if (mce)       v = wd;
                else if (pmce) v = {wd[7:4], old_v[3:0]};
                else           v = old_v;
            end
            default: v = wd;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/codec_cal_fsm.sv
module codec_cal_fsm
    import codec_regs_pkg::*;
#(
    parameter int unsigned CAL_READS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic poll,
    output logic busy
);
    localparam int unsigned CNT_W = $clog2(CAL_READS + 1);

    cal_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CAL_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            CAL_IDLE: begin
                if (start) begin
                    state_d = CAL_BUSY;
                    cnt_d   = CNT_W'(CAL_READS);
                end
            end
            CAL_BUSY: begin
                if (start) begin
                    cnt_d = CNT_W'(CAL_READS);
                end else if (poll) begin
                    if (cnt_q == CNT_W'(1)) begin
                        state_d = CAL_IDLE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q - CNT_W'(1);
                    end
                end
            end
            default: begin
                state_d = CAL_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    assign busy = (state_q == CAL_BUSY);

endmodule

// File: rtl/codec_irq_ctrl.sv
module codec_irq_ctrl
    import codec_regs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic sts_wr,
    input  logic pi_ack,
    output logic pending
);
    irq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:    if (evt) state_d = IRQ_PENDING;
            IRQ_PENDING: if (!evt && (sts_wr || pi_ack)) state_d = IRQ_IDLE;
            default:     state_d = IRQ_IDLE;
        endcase
    end

    assign pending = (state_q == IRQ_PENDING);

endmodule

// File: rtl/codec_reg_file.sv
module codec_reg_file
    import codec_regs_pkg::*;
#(
    parameter int unsigned NUM_REGS = 32,
    localparam int unsigned ADDR_W = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              mce,
    input  logic              clr_flags,
    input  logic              set_pi,
    output logic [BYTE_W-1:0] rd_val,
    output logic [BYTE_W-1:0] fmt_q,
    output logic [BYTE_W-1:0] ifcfg_q,
    output logic [BYTE_W-1:0] pinctl_q,
    output logic [BYTE_W-1:0] modeid_q,
    output logic [BYTE_W-1:0] altstat_q
);
    logic [BYTE_W-1:0] regs [NUM_REGS];
    logic              pmce;

    assign pmce = regs[REG_ALTSTAT][PMCE_BIT];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        if (g == REG_ALTSTAT) begin : g_alt
            logic [BYTE_W-1:0] base;
            always_comb begin
                base = regs[g];
                if (clr_flags)                      base = regs[g] & ~ALT_FLAG_MASK;
                else if (we && addr == ADDR_W'(g))  base = wdata;
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      regs[g] <= reg_reset(g);
                else if (set_pi) regs[g] <= base | (BYTE_W'(1) << PI_BIT);
                else             regs[g] <= base;
            end
        end else begin : g_std
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    regs[g] <= reg_reset(g);
                else if (we && addr == ADDR_W'(g))
                    regs[g] <= merge_write(g, regs[g], wdata, mce, pmce);
            end
        end
    end

    assign rd_val    = regs[addr];
    assign fmt_q     = regs[REG_FMT];
    assign ifcfg_q   = regs[REG_IFCFG];
    assign pinctl_q  = regs[REG_PINCTL];
    assign modeid_q  = regs[REG_MODEID];
    assign altstat_q = regs[REG_ALTSTAT];

endmodule

// File: rtl/codec_host_regs.sv
module codec_host_regs
    import codec_regs_pkg::*;
#(
    parameter int unsigned NUM_REGS  = 32,
    parameter int unsigned CAL_READS = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] host_sel,
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    input  logic       play_evt,
    output logic [7:0] fmt_q,
    output logic       play_en,
    output logic       irq_en,
    output logic       irq
);
    localparam int unsigned ADDR_W = $clog2(NUM_REGS);
    localparam int unsigned IDX_W  = BYTE_W - 1;

    port_e             port;
    logic              idx_we, dat_we, dat_re, sts_we;
    logic [IDX_W-1:0]  idx_q;
    logic              mce, mode2, pmce, mce_rise, pi_ack;
    logic [ADDR_W-1:0] iaddr;
    logic [BYTE_W-1:0] rd_val, ifcfg_q, pinctl_q, modeid_q, altstat_q;
    logic              cal_busy, int_pend;

    assign port   = port_e'(host_sel);
    assign idx_we = host_wr && (port == PORT_INDEX);
    assign dat_we = host_wr && (port == PORT_DATA);
    assign sts_we = host_wr && (port == PORT_STATUS);
    assign dat_re = host_rd && (port == PORT_DATA);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      idx_q <= IDX_W'(8'h40);
        else if (idx_we) idx_q <= host_wdata[IDX_W-1:0];
    end

    assign mce   = idx_q[MCE_BIT];
    assign mode2 = modeid_q[MODE2_BIT];
    assign pmce  = altstat_q[PMCE_BIT];
    assign iaddr = mode2 ? idx_q[ADDR_W-1:0] : {1'b0, idx_q[ADDR_W-2:0]};

    assign mce_rise = idx_we && !mce && host_wdata[MCE_BIT] && (ifcfg_q[4:3] != 2'b00);
    assign pi_ack   = dat_we && (iaddr == ADDR_W'(REG_ALTSTAT))
                      && altstat_q[PI_BIT] && !host_wdata[PI_BIT];

    codec_reg_file #(.NUM_REGS(NUM_REGS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (dat_we),
        .addr      (iaddr),
        .wdata     (host_wdata),
        .mce       (mce),
        .clr_flags (sts_we),
        .set_pi    (play_evt),
        .rd_val    (rd_val),
        .fmt_q     (fmt_q),
        .ifcfg_q   (ifcfg_q),
        .pinctl_q  (pinctl_q),
        .modeid_q  (modeid_q),
        .altstat_q (altstat_q)
    );

    codec_cal_fsm #(.CAL_READS(CAL_READS)) u_cal (
        .clk   (clk),
        .rst_n (rst_n),
        .start (mce_rise),
        .poll  (dat_re && (iaddr == ADDR_W'(REG_ERRSTAT))),
        .busy  (cal_busy)
    );

    codec_irq_ctrl u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (play_evt),
        .sts_wr  (sts_we),
        .pi_ack  (pi_ack),
        .pending (int_pend)
    );

    always_comb begin
        host_rdata = '0;
        unique case (port)
            PORT_INDEX: host_rdata = {1'b0, idx_q};
            PORT_DATA: begin
                host_rdata = rd_val;
                if (iaddr == ADDR_W'(REG_ERRSTAT) && cal_busy)
                    host_rdata[CALBSY_BIT] = 1'b1;
            end
            PORT_STATUS: host_rdata[INT_BIT] = int_pend;
            PORT_PIO:    host_rdata = '0;
            default:     host_rdata = '0;
        endcase
    end

    assign play_en = ifcfg_q[PEN_BIT];
    assign irq_en  = pinctl_q[IEN_BIT];
    assign irq     = int_pend;

endmodule

// File: rtl/codec_host_regs_chk.sv
module codec_host_regs_chk #(
    parameter int unsigned ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        host_sel,
    input logic              host_wr,
    input logic              host_rd,
    input logic [7:0]        host_wdata,
    input logic [7:0]        host_rdata,
    input logic              play_evt,
    input logic              irq,
    input logic [7:0]        fmt_q,
    input logic [7:0]        modeid_q,
    input logic [ADDR_W-1:0] iaddr,
    input logic              mce,
    input logic              pmce,
    input logic              mce_rise,
    input logic              cal_busy
);
    logic fmt_wr, mode_wr;
    assign fmt_wr  = host_wr && host_sel == 2'd1 && iaddr == ADDR_W'(8);
    assign mode_wr = host_wr && host_sel == 2'd1 && iaddr == ADDR_W'(12);

    AST_IDX_BIT7_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_sel == 2'd0) |-> !host_rdata[7]); // R2

    AST_MODE_ONLY_BIT6: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> ((modeid_q & 8'hBF) == ($past(modeid_q) & 8'hBF))
                    && (modeid_q[6] == $past(host_wdata[6]))); // R4

    AST_FMT_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_wr && !mce && !pmce) |=> $stable(fmt_q)); // R7

    AST_FMT_LOW_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_wr && !mce && pmce) |=> (fmt_q[3:0] == $past(fmt_q[3:0]))); // R7

    AST_CAL_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        mce_rise |=> cal_busy); // R8

    AST_EVT_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        play_evt |=> irq); // R10

    AST_STS_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel == 2'd2 && !play_evt) |=> !irq); // R11

    AST_PIO_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_sel == 2'd3) |-> (host_rdata == 8'h00)); // R13

endmodule

bind codec_host_regs codec_host_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_sel   (host_sel),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .play_evt   (play_evt),
    .irq        (irq),
    .fmt_q      (fmt_q),
    .modeid_q   (modeid_q),
    .iaddr      (iaddr),
    .mce        (mce),
    .pmce       (pmce),
    .mce_rise   (mce_rise),
    .cal_busy   (cal_busy)
);

// File: tb/codec_host_regs_tb.sv
module codec_host_regs_tb;
    localparam int CAL = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] host_sel = '0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       play_evt = 1'b0;
    logic [7:0] fmt_q;
    logic       play_en, irq_en, irq;

    always #2 clk = ~clk;

    codec_host_regs #(.NUM_REGS(32), .CAL_READS(CAL)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .play_evt(play_evt), .fmt_q(fmt_q), .play_en(play_en),
        .irq_en(irq_en), .irq(irq)
    );

    // reference model built from the requirements
    logic [7:0] mr [32];
    logic [6:0] midx;
    logic       mint;
    int         mcal;
    int         nchk = 0;
    int         nfail = 0;
    bit         done = 0;

    function automatic logic [7:0] rstv(int i);
        case (i)
            2, 3, 4, 5, 18, 19: return 8'h88;
            6, 7:               return 8'h80;
            9:                  return 8'h08;
            12:                 return 8'h8A;
            25, 26:             return 8'hA0;
            default:            return 8'h00;
        endcase
    endfunction

    function automatic int ia();
        return mr[12][6] ? int'(midx[4:0]) : int'(midx[3:0]);
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic outs();
        chk("R7 fmt_q", fmt_q, mr[8]);
        chk("R5 play_en", {7'b0, play_en}, {7'b0, mr[9][0]});
        chk("R5 irq_en", {7'b0, irq_en}, {7'b0, mr[10][1]});
        chk("R10 irq", {7'b0, irq}, {7'b0, mint});
    endtask

    task automatic wr(logic [1:0] sel, logic [7:0] d);
        int a;
        @(negedge clk);
        host_sel = sel; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
        case (sel)
            2'd0: begin
                if (!midx[6] && d[6] && mr[9][4:3] != 2'b00) mcal = CAL;
                midx = d[6:0];
            end
            2'd1: begin
                a = ia();
                case (a)
                    11: ;
                    12: mr[12][6] = d[6];
                    9:  mr[9] = d & 8'hDF;
                    8: begin
                        if (midx[6])        mr[8] = d;
                        else if (mr[24][4]) mr[8] = {d[7:4], mr[8][3:0]};
                    end
                    24: begin
                        if (mr[24][4] && !d[4]) mint = 1'b0;
                        mr[24] = d;
                    end
                    default: mr[a] = d;
                endcase
            end
            2'd2: begin
                mint = 1'b0;
                mr[24] = mr[24] & 8'h8F;
            end
            default: ;
        endcase
        outs();
    endtask

    task automatic rd(logic [1:0] sel, string tag);
        logic [7:0] exp;
        int a;
        a = ia();
        case (sel)
            2'd0: exp = {1'b0, midx};
            2'd1: exp = mr[a] | ((a == 11 && mcal != 0) ? 8'h20 : 8'h00);
            2'd2: exp = {7'b0, mint};
            default: exp = 8'h00;
        endcase
        @(negedge clk);
        host_sel = sel; host_rd = 1'b1;
        #1 chk(tag, host_rdata, exp);
        @(negedge clk);
        host_rd = 1'b0;
        if (sel == 2'd1 && a == 11 && mcal != 0) mcal--;
    endtask

    task automatic evt(bit with_sts);
        @(negedge clk);
        play_evt = 1'b1;
        if (with_sts) begin host_sel = 2'd2; host_wr = 1'b1; end
        @(negedge clk);
        play_evt = 1'b0; host_wr = 1'b0;
        if (with_sts) mr[24] = mr[24] & 8'h8F;
        mint = 1'b1;
        mr[24][4] = 1'b1;
        outs();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) mr[i] = rstv(i);
        midx = 7'h40; mint = 1'b0; mcal = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        outs();
        rd(2'd0, "R1 index");
        rd(2'd2, "R1 status");
        rd(2'd3, "R1 pio");
        for (int i = 0; i < 16; i++) begin wr(2'd0, 8'(i)); rd(2'd1, "R1 reg"); end
        wr(2'd0, 8'd12); wr(2'd1, 8'hCA); rd(2'd1, "R4 mode2 on");
        for (int i = 16; i < 32; i++) begin wr(2'd0, 8'(i)); rd(2'd1, "R1 reg"); end

        // R2: index sweep
        for (int v = 0; v < 256; v++) begin wr(2'd0, 8'(v)); rd(2'd0, "R2 index"); end

        // R4: mode register sweep
        wr(2'd0, 8'd12);
        for (int v = 0; v < 256; v++) begin wr(2'd1, 8'(v)); rd(2'd1, "R4 mode"); end

        // R3: fill all registers with MODE2 on, then alias with MODE2 off
        for (int i = 0; i < 32; i++) begin
            if (i == 11 || i == 12 || i == 24) continue;
            wr(2'd0, 8'(i) | 8'h40); wr(2'd1, 8'(i * 29 + 3)); rd(2'd1, "R3 fill");
        end
        wr(2'd0, 8'h4C); wr(2'd1, 8'h00);
        for (int v = 0; v < 32; v++) begin wr(2'd0, 8'(v)); rd(2'd1, "R3 narrow"); end
        wr(2'd0, 8'd12); wr(2'd1, 8'h40);

        // R5: interface config and pin control
        wr(2'd0, 8'd9);
        for (int v = 0; v < 256; v++) begin wr(2'd1, 8'(v)); rd(2'd1, "R5 ifcfg"); end
        wr(2'd0, 8'd10);
        for (int v = 0; v < 256; v++) begin wr(2'd1, 8'(v)); rd(2'd1, "R5 pinctl"); end

        // R6: read-only error register
        wr(2'd0, 8'd11);
        for (int v = 0; v < 256; v += 3) begin wr(2'd1, 8'(v)); rd(2'd1, "R6 errstat"); end

        // R7: format gating under each enable combination
        for (int g = 0; g < 3; g++) begin
            if (g == 0) wr(2'd0, 8'h48);
            else begin
                wr(2'd0, 8'd24); wr(2'd1, (g == 1) ? 8'h10 : 8'h00); wr(2'd0, 8'd8);
            end
            for (int v = 0; v < 256; v += 7) begin wr(2'd1, 8'(v)); rd(2'd1, "R7 fmt"); end
        end

        // R8/R9: calibration start qualification and countdown
        for (int k = 0; k < 4; k++) begin
            wr(2'd0, 8'd9); wr(2'd1, 8'(k << 3));
            wr(2'd0, 8'h0B); wr(2'd0, 8'h4B);
            for (int p = 0; p < CAL + 2; p++) rd(2'd1, "R9 calpoll");
            rd(2'd1, "R8 cal done");
        end
        wr(2'd0, 8'h0B); wr(2'd0, 8'h4B); rd(2'd1, "R9 poll1");
        wr(2'd0, 8'h0B); wr(2'd0, 8'h4B);
        for (int p = 0; p < CAL + 1; p++) rd(2'd1, "R8 reload");

        // R10..R12: interrupt set and acknowledge paths
        evt(1'b0); rd(2'd2, "R10 status");
        wr(2'd0, 8'd24); rd(2'd1, "R10 pi");
        wr(2'd1, 8'h7F); wr(2'd2, 8'h00);
        rd(2'd2, "R11 status"); rd(2'd1, "R11 alt");
        evt(1'b0); wr(2'd1, 8'h30); rd(2'd2, "R12 kept");
        wr(2'd1, 8'h20); rd(2'd2, "R12 ack");
        wr(2'd1, 8'h60); evt(1'b1); rd(2'd2, "R11 evt wins"); rd(2'd1, "R11 alt evt");
        wr(2'd2, 8'hFF); rd(2'd2, "R11 clear");

        // R13: PIO port
        for (int v = 0; v < 256; v += 17) begin wr(2'd3, 8'(v)); rd(2'd3, "R13 pio"); end
        rd(2'd0, "R13 index intact");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule